// File: doc/BRIEF.md
# Programmable Self-Synchronizing Descrambler

This block undoes multiplicative scrambling on a serial bit stream. Every qualified input bit goes into a short delay line of recently received bits. The output bit is the input bit XORed with the modulo-2 sum of whichever delay-line stages a runtime tap mask selects. This is polynomial division by the scrambler's feedback polynomial.

The delay line is fed with the received bits themselves and never with the recovered data. After the descrambler has seen as many bits as it has stages, it locks onto any transmitter state. No seed, preload or alignment handshake is needed. The cost of this property is error multiplication: one channel error reappears once directly and once more for every enabled tap.

Use: present one bit per cycle with its valid flag, and hold the tap mask at the value that matches the transmitter. The recovered bit comes out one clock later with a matching valid flag.

Top module: `mult_descrambler`

## Requirements
- R1: While `srst` is high at a clock edge, the following cycle shows `out_vld`=0 and `out_bit`=0, and every delay-line stage is cleared. The first valid bit after reset therefore comes out unchanged, whatever the mask.
- R2: `out_vld` equals `in_vld` delayed by exactly one clock.
- R3: For a valid input, the next cycle's `out_bit` equals `in_bit` XOR the parity of the enabled stages. Mask bit k enables stage k+1, and stage 1 holds the most recent previously received valid bit.
- R4: With `tap_mask` all zero, `out_bit` one cycle later equals the input bit (pass-through).
- R5: Cycles with `in_vld` low shift nothing: the delay line keeps its contents and `out_bit` holds its last value, whatever `in_bit` does.
- R6: The delay line stores received bits, not recovered bits. Starting from a cleared state, the block reproduces the original data of a matching scrambler that began from any state, exactly from the eighth valid bit onward.
- R7: A new `tap_mask` value applies to the very next valid bit, and the stored history is not cleared by the change.
- R8: With exactly two taps enabled (mask 7'b1001000, stages 4 and 7), a single flipped channel bit yields exactly three wrong output bits: at the flip position and 4 and 7 bits after it.
- R9: With the same two-tap mask, two channel errors 3 bits apart (the tap spacing) cancel in one shared output position, which gives 4 wrong output bits instead of 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| srst | input | 1 | Synchronous reset, active high |
| in_bit | input | 1 | Received (scrambled) serial bit |
| in_vld | input | 1 | Qualifies `in_bit` for this cycle |
| tap_mask | input | REG_LEN | Tap enables; bit k selects stage k+1 |
| out_bit | output | 1 | Recovered bit, registered |
| out_vld | output | 1 | Qualifies `out_bit`; `in_vld` delayed one cycle |

## Verification
The bench builds the block with the default `REG_LEN` of 7. At that size the whole mask space of 128 values can be swept, including zero, single taps at both ends of the delay line and the all-ones mask. The 7-bit delay line is also short enough that a bench-side scrambler can start from an arbitrary state and lock is visible within a handful of bits. With the two-tap mask, single and tap-spaced error pairs can be placed and the exact error counts predicted.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    localparam int unsigned DSC_DEFAULT_LEN = 7;

    typedef struct packed {
        logic data;
        logic valid;
    } dsc_out_t;

endpackage

// File: rtl/dsc_hist_reg.sv
module dsc_hist_reg #(
    parameter int unsigned LEN = 7
) (
    input  logic           clk,
    input  logic           srst,
    input  logic           shift_en,
    input  logic           din,
    output logic [LEN-1:0] hist_o
);

    localparam int unsigned UPPER = LEN - 1;

    logic [LEN-1:0] hist_d;
    logic [LEN-1:0] hist_q;

    // index 0 is stage 1 (newest received bit)
    always_comb begin
        hist_d = hist_q;
        if (shift_en) begin
            hist_d = {hist_q[UPPER-1:0], din};
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            hist_q <= '0;
        end else begin
            hist_q <= hist_d;
        end
    end

    assign hist_o = hist_q;

endmodule

// File: rtl/dsc_tap_sum.sv
module dsc_tap_sum #(
    parameter int unsigned LEN = 7
) (
    input  logic [LEN-1:0] hist_i,
    input  logic [LEN-1:0] mask_i,
    output logic           parity_o
);

    logic [LEN-1:0] term;

    for (genvar g = 0; g < LEN; g++) begin : g_term
        assign term[g] = hist_i[g] & mask_i[g];
    end

    assign parity_o = ^term;

endmodule

// File: rtl/mult_descrambler.sv
module mult_descrambler
    import dsc_pkg::*;
#(
    parameter int unsigned REG_LEN = DSC_DEFAULT_LEN
) (
    input  logic               clk,
    input  logic               srst,
    input  logic               in_bit,
    input  logic               in_vld,
    input  logic [REG_LEN-1:0] tap_mask,
    output logic               out_bit,
    output logic               out_vld
);

    logic [REG_LEN-1:0] hist_w;
    logic               fb_par;
    dsc_out_t           out_d;
    dsc_out_t           out_q;

    dsc_hist_reg #(.LEN(REG_LEN)) u_hist (
        .clk      (clk),
        .srst     (srst),
        .shift_en (in_vld),
        .din      (in_bit),
        .hist_o   (hist_w)
    );

    dsc_tap_sum #(.LEN(REG_LEN)) u_taps (
        .hist_i   (hist_w),
        .mask_i   (tap_mask),
        .parity_o (fb_par)
    );

    always_comb begin
        out_d       = out_q;
        out_d.valid = in_vld;
        if (in_vld) begin
            out_d.data = in_bit ^ fb_par;
        end
    end

    always_ff @(posedge clk) begin
        if (srst) begin
            out_q <= '0;
        end else begin
            out_q <= out_d;
        end
    end

    assign out_bit = out_q.data;
    assign out_vld = out_q.valid;

endmodule

// File: rtl/dsc_checker.sv
module dsc_checker #(
    parameter int unsigned REG_LEN = 7
) (
    input logic               clk,
    input logic               srst,
    input logic               in_bit,
    input logic               in_vld,
    input logic [REG_LEN-1:0] tap_mask,
    input logic               out_bit,
    input logic               out_vld,
    input logic [REG_LEN-1:0] hist_w
);

    a_r1_reset_clears: assert property (@(posedge clk)
        srst |=> (!out_vld && !out_bit && hist_w == '0));

    a_r2_valid_rise: assert property (@(posedge clk) disable iff (srst)
        in_vld |=> out_vld);

    a_r2_valid_low: assert property (@(posedge clk) disable iff (srst)
        !in_vld |=> !out_vld);

    a_r3_stage1_tap: assert property (@(posedge clk) disable iff (srst)
        (in_vld && tap_mask == REG_LEN'(1)) |=> out_bit == ($past(in_bit) ^ $past(hist_w[0])));

    a_r4_zero_mask_pass: assert property (@(posedge clk) disable iff (srst)
        (in_vld && tap_mask == '0) |=> out_bit == $past(in_bit));

    a_r5_output_hold: assert property (@(posedge clk) disable iff (srst)
        !in_vld |=> $stable(out_bit));

    a_r5_history_hold: assert property (@(posedge clk) disable iff (srst)
        !in_vld |=> $stable(hist_w));

    a_r6_history_takes_input: assert property (@(posedge clk) disable iff (srst)
        in_vld |=> hist_w[0] == $past(in_bit));

endmodule

bind mult_descrambler dsc_checker #(.REG_LEN(REG_LEN)) u_chk (
    .clk      (clk),
    .srst     (srst),
    .in_bit   (in_bit),
    .in_vld   (in_vld),
    .tap_mask (tap_mask),
    .out_bit  (out_bit),
    .out_vld  (out_vld),
    .hist_w   (hist_w)
);

// File: tb/tb_mult_descrambler.sv
module tb_mult_descrambler;

    localparam int L = 7;

    logic         clk = 1'b0;
    logic         srst = 1'b1;
    logic         in_bit = 1'b0;
    logic         in_vld = 1'b0;
    logic [L-1:0] tap_mask = '0;
    logic         out_bit;
    logic         out_vld;

    int    checks = 0;
    int    fails = 0;
    bit    cmp_en = 1'b0;
    bit    done = 1'b0;
    string phase = "R1";

    // reference model state
    bit rq[$];
    bit exp_bit = 1'b0;
    bit exp_vld = 1'b0;

    always #2.5 clk = ~clk;

    mult_descrambler #(.REG_LEN(L)) dut (
        .clk(clk), .srst(srst), .in_bit(in_bit), .in_vld(in_vld),
        .tap_mask(tap_mask), .out_bit(out_bit), .out_vld(out_vld)
    );

    task automatic check(input string req, input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference, updated on every clock edge
    always @(posedge clk) begin
        if (srst) begin
            rq = {};
            for (int i = 0; i < L; i++) rq.push_back(1'b0);
            exp_bit = 1'b0;
            exp_vld = 1'b0;
        end else begin
            exp_vld = in_vld;
            if (in_vld) begin
                bit p;
                p = 1'b0;
                for (int k = 0; k < L; k++) if (tap_mask[k]) p ^= rq[k];
                exp_bit = in_bit ^ p;
                rq.push_front(in_bit);
                void'(rq.pop_back());
            end
        end
    end

    always @(negedge clk) begin
        if (cmp_en) begin
            check("R2", out_vld, exp_vld, "out_vld vs model");
            check(phase, out_bit, exp_bit, "out_bit vs model");
        end
    end

    function automatic bit parity7(input bit [L-1:0] h, input bit [L-1:0] m);
        return ^(h & m);
    endfunction

    task automatic do_reset();
        @(negedge clk);
        srst = 1'b1; in_vld = 1'b0;
        @(negedge clk);
        @(negedge clk);
        srst = 1'b0;
    endtask

    task automatic send(input bit b, output bit r);
        @(negedge clk);
        in_bit = b; in_vld = 1'b1;
        @(negedge clk);
        r = out_bit;
        in_vld = 1'b0;
    endtask

    // scramble data with a tx model, optional channel flips, count output errors
    task automatic err_run(input bit [L-1:0] m, input bit [L-1:0] tx_init,
                           input int f1, input int f2, input int from,
                           output int nerr, output int first_bad);
        bit [L-1:0] txh;
        bit d, s, r;
        txh = tx_init;
        nerr = 0;
        first_bad = -1;
        tap_mask = m;
        for (int i = 0; i < 60; i++) begin
            d = 1'($urandom_range(0, 1));
            s = d ^ parity7(txh, m);
            txh = {txh[L-2:0], s};
            if (i == f1 || i == f2) s = ~s;
            send(s, r);
            if (i >= from && r != d) begin
                nerr++;
                if (first_bad < 0) first_bad = i;
            end
        end
    endtask

    initial begin
        bit r;
        int ne, fb;
        repeat (3) @(negedge clk);
        srst = 1'b0;
        do_reset();
        // R1: reset state
        check("R1", out_vld, 0, "out_vld after reset");
        check("R1", out_bit, 0, "out_bit after reset");
        tap_mask = '1;
        send(1'b1, r);
        check("R1", r, 1, "first bit after reset with all taps");
        cmp_en = 1'b1;

        // R3: sweep every mask with random data
        phase = "R3";
        for (int m = 0; m < 128; m++) begin
            tap_mask = 7'(m);
            for (int j = 0; j < 12; j++) send(1'($urandom_range(0, 1)), r);
        end

        // R4: zero mask pass-through
        phase = "R4";
        tap_mask = '0;
        for (int j = 0; j < 16; j++) begin
            bit b;
            b = 1'($urandom_range(0, 1));
            send(b, r);
            check("R4", r, b, "pass-through");
        end

        // R5: idle gaps with toggling in_bit
        phase = "R5";
        tap_mask = 7'b1010011;
        for (int j = 0; j < 20; j++) begin
            bit held;
            send(1'($urandom_range(0, 1)), r);
            held = out_bit;
            for (int g = 0; g < 4; g++) begin
                @(negedge clk);
                in_bit = ~in_bit;
            end
            check("R5", out_bit, held, "out_bit held while idle");
        end

        // R7: mask switched between consecutive valid bits
        phase = "R7";
        for (int j = 0; j < 40; j++) begin
            @(negedge clk);
            tap_mask = 7'($urandom_range(0, 127));
            in_bit = 1'($urandom_range(0, 1));
            in_vld = 1'b1;
        end
        @(negedge clk);
        in_vld = 1'b0;
        @(negedge clk);

        // R6: self-sync from arbitrary transmitter state
        phase = "R6";
        cmp_en = 1'b0;
        do_reset();
        cmp_en = 1'b1;
        err_run(7'b1001000, 7'h5A, -1, -1, 7, ne, fb);
        check("R6", ne, 0, "errors after lock, tx state 5A");
        do_reset();
        err_run(7'b1111111, 7'h33, -1, -1, 7, ne, fb);
        check("R6", ne, 0, "errors after lock, all taps");

        // R8: single channel error, two taps
        phase = "R8";
        do_reset();
        err_run(7'b1001000, 7'h00, 20, -1, 0, ne, fb);
        check("R8", ne, 3, "output errors from one channel error");
        check("R8", fb, 20, "first error position");

        // R9: two errors at tap spacing cancel once
        phase = "R9";
        do_reset();
        err_run(7'b1001000, 7'h00, 20, 23, 0, ne, fb);
        check("R9", ne, 4, "output errors from tap-spaced pair");

        cmp_en = 1'b0;
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog R2 actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule